// File: doc/BRIEF.md
# Voltage Sensor Access Sequencer

This block lets fabric logic operate an on-chip multi-channel voltage-sensing converter through its port-level control pins. A start request brings the sensor up in a fixed order. First the core-control line is raised. After a programmable gap the sensor reset is released. After a second gap an 8-bit configuration word is shifted out one bit per clock while a configuration strobe is held high. When the strobe drops, the sensor begins converting.

While the sensor runs, the sequencer watches its end-of-conversion and end-of-sequence flags. It captures each 6-bit result on the clock where end-of-conversion drops. It hands every result to the user with a one-cycle valid pulse and a channel index. The sensor repeats the selected channel sequence for as long as it is left running.

A new configuration requested mid-sequence is parked until a full sequence has ended and is then shifted in without a new bring-up. A stop request, or the sequencer's own reset, parks the sensor with core-control low and the sensor reset high.

Top module: `sensor_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `sens_ctl_o`=0, `sens_rst_o`=1, `sens_cfg_en_o`=0, `sens_cfg_bit_o`=0 and `smp_valid_o`=0.
- R2: A `start_i` pulse from idle whose mode field is valid raises `sens_ctl_o` on the next cycle. `sens_rst_o` stays high for exactly GAP cycles of `sens_ctl_o` high.
- R3: After `sens_rst_o` falls, `sens_cfg_en_o` rises exactly GAP cycles later.
- R4: `sens_cfg_en_o` stays high for exactly CFG_W (8) cycles. During those cycles `sens_cfg_bit_o` presents the configuration MSB first, bit 7 in the first cycle. `sens_cfg_bit_o` is 0 whenever the strobe is low.
- R5: The mode field is `cfg_i[7:6]`. A `start_i` carrying mode 2'b11 is ignored, both from idle and while converting.
- R6: A result is taken on the clock where `sens_eoc_i` is low after having been high in the previous cycle. In the next cycle `smp_valid_o` is high for one cycle and `smp_data_o` equals the `sens_data_i` value of the capture cycle.
- R7: `smp_chan_o` is 0 for the first result after configuration and increments by one per result. It returns to 0 after a result whose last high end-of-conversion cycle also had `sens_eos_i` high.
- R8: With no stop and no reconfiguration, the sequencer keeps capturing repeated sequences without touching the control lines.
- R9: A valid `start_i` while converting is held. The strobe stays low until the result closing a sequence is captured. The strobe rises in the same cycle that result is presented, shifting the held word.
- R10: A `stop_i` pulse drives `sens_ctl_o`=0 and `sens_rst_o`=1 on the next cycle and returns to idle, from which a new start works.
- R11: Raising `rst` during conversion forces the R1 state on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or reconfiguration request (one cycle) |
| stop_i | input | 1 | Stop request (one cycle) |
| cfg_i | input | 8 | Configuration word, mode field in bits 7:6 |
| sens_ctl_o | output | 1 | Sensor core-control enable |
| sens_rst_o | output | 1 | Sensor reset, active high |
| sens_cfg_en_o | output | 1 | Configuration strobe |
| sens_cfg_bit_o | output | 1 | Serial configuration data |
| sens_eoc_i | input | 1 | Sensor end-of-conversion flag |
| sens_eos_i | input | 1 | Sensor end-of-sequence flag |
| sens_data_i | input | 6 | Sensor conversion result |
| smp_valid_o | output | 1 | Captured sample valid pulse |
| smp_data_o | output | 6 | Captured sample |
| smp_chan_o | output | 3 | Channel index of the captured sample |

## Verification
A wrong state or gap count shows up directly on the three control outputs. A strobe that rises one cycle early or late, or lasts other than eight cycles, is visible within about a dozen cycles of the start pulse. A stuck shift register shows as a wrong serial bit in the first strobe window. A lost edge detector or channel counter shows on the very next conversion, as a missing valid pulse, a wrong sample, or an index that fails to return to 0 after the closing result. A reconfiguration that is not held is seen as a strobe rising between results of a sequence.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ENA  = 3'd1,
    ST_RELS = 3'd2,
    ST_CFG  = 3'd3,
    ST_RUN  = 3'd4
  } ss_state_e;

  // The all-ones mode is not handled by this sequencer.
  function automatic logic mode_ok(input logic [1:0] mode);
    return mode != 2'b11;
  endfunction
endpackage

// File: rtl/ss_shift.sv
module ss_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '0;
    else if (load)  sh_q <= word;
    else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb = sh_q[W-1];
endmodule

// File: rtl/ss_capture.sv
module ss_capture #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          eoc_i,
  input  logic          eos_i,
  input  logic [DW-1:0] data_i,
  output logic          fall_o,
  output logic          last_o,
  output logic          vld_o,
  output logic [DW-1:0] data_o
);
  logic eoc_q, eos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_q <= 1'b0;
      eos_q <= 1'b0;
    end else begin
      eoc_q <= eoc_i;
      eos_q <= eos_i;
    end
  end

  assign fall_o = arm & eoc_q & ~eoc_i;
  assign last_o = eos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o <= fall_o;
      if (fall_o) data_o <= data_i;
    end
  end
endmodule

// File: rtl/sensor_seq.sv
module sensor_seq
  import ss_pkg::*;
#(
  parameter int GAP   = 2,
  parameter int CFG_W = 8,
  parameter int DW    = 6,
  parameter int CHW   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             sens_ctl_o,
  output logic             sens_rst_o,
  output logic             sens_cfg_en_o,
  output logic             sens_cfg_bit_o,
  input  logic             sens_eoc_i,
  input  logic             sens_eos_i,
  input  logic [DW-1:0]    sens_data_i,
  output logic             smp_valid_o,
  output logic [DW-1:0]    smp_data_o,
  output logic [CHW-1:0]   smp_chan_o
);
  localparam int SPAN = (GAP > CFG_W) ? GAP : CFG_W;
  localparam int CNTW = $clog2(SPAN + 1);
  localparam logic [CNTW-1:0] GAP_LAST = CNTW'(GAP - 1);
  localparam logic [CNTW-1:0] CFG_LAST = CNTW'(CFG_W - 1);

  function automatic logic [CHW-1:0] chan_next(input logic [CHW-1:0] c,
                                               input logic last);
    return last ? '0 : c + 1'b1;
  endfunction

  ss_state_e        st_q;
  logic [CNTW-1:0]  cnt_q;
  logic [CFG_W-1:0] pend_cfg_q;
  logic             pend_v_q;
  logic [CHW-1:0]   chan_q;
  logic [CHW-1:0]   smp_chan_q;

  // named internal events
  logic req_ok;
  logic run_w;
  logic eoc_fall;
  logic eos_last;
  logic go_cfg;
  logic sh_msb;

  assign req_ok = start_i & mode_ok(cfg_i[CFG_W-1 -: 2]);
  assign run_w  = (st_q == ST_RUN);
  assign go_cfg = ((st_q == ST_RELS) && (cnt_q == GAP_LAST))
                | (run_w && eoc_fall && eos_last && pend_v_q);

  ss_capture #(.DW(DW)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .arm    (run_w),
    .eoc_i  (sens_eoc_i),
    .eos_i  (sens_eos_i),
    .data_i (sens_data_i),
    .fall_o (eoc_fall),
    .last_o (eos_last),
    .vld_o  (smp_valid_o),
    .data_o (smp_data_o)
  );

  ss_shift #(.W(CFG_W)) u_sh (
    .clk   (clk),
    .rst   (rst),
    .load  (go_cfg & ~stop_i),
    .word  (pend_cfg_q),
    .shift (st_q == ST_CFG),
    .msb   (sh_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      pend_cfg_q <= '0;
      pend_v_q   <= 1'b0;
      chan_q     <= '0;
    end else if (stop_i) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      pend_v_q <= 1'b0;
      chan_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_ok) begin
          st_q       <= ST_ENA;
          cnt_q      <= '0;
          pend_cfg_q <= cfg_i;
        end
        ST_ENA: begin
          if (cnt_q == GAP_LAST) begin
            st_q  <= ST_RELS;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_RELS: begin
          if (go_cfg) begin
            st_q  <= ST_CFG;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_CFG: begin
          chan_q <= '0;
          if (cnt_q == CFG_LAST) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_RUN: begin
          if (eoc_fall) chan_q <= chan_next(chan_q, eos_last);
          if (go_cfg) begin
            st_q     <= ST_CFG;
            cnt_q    <= '0;
            pend_v_q <= 1'b0;
          end else if (req_ok) begin
            pend_v_q   <= 1'b1;
            pend_cfg_q <= cfg_i;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           smp_chan_q <= '0;
    else if (eoc_fall) smp_chan_q <= chan_q;
  end

  assign smp_chan_o     = smp_chan_q;
  assign sens_ctl_o     = (st_q != ST_IDLE);
  assign sens_rst_o     = (st_q == ST_IDLE) || (st_q == ST_ENA);
  assign sens_cfg_en_o  = (st_q == ST_CFG);
  assign sens_cfg_bit_o = sens_cfg_en_o & sh_msb;
endmodule

// File: rtl/ss_chk.sv
module ss_chk #(
  parameter int GAP   = 2,
  parameter int CFG_W = 8
) (
  input logic clk,
  input logic rst,
  input logic ctl,
  input logic srst,
  input logic en,
  input logic sbit,
  input logic eoc,
  input logic vld,
  input logic run,
  input logic fall,
  input logic last
);
  logic [7:0] ena_cnt, rel_cnt, len_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_cnt <= '0;
      rel_cnt <= '0;
      len_cnt <= '0;
    end else begin
      if (!ctl) ena_cnt <= '0;
      else if (srst && ena_cnt != 8'hFF) ena_cnt <= ena_cnt + 1'b1;
      if (srst) rel_cnt <= '0;
      else if (!en && rel_cnt != 8'hFF) rel_cnt <= rel_cnt + 1'b1;
      if (!en) len_cnt <= '0;
      else if (len_cnt != 8'hFF) len_cnt <= len_cnt + 1'b1;
    end
  end

  // R10
  parked_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl |-> srst);

  // R3
  strobe_needs_release_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (ctl && !srst));

  // R2
  release_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(srst) && ctl) |-> (ena_cnt >= 8'(GAP)));

  // R3
  config_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> (rel_cnt >= 8'(GAP)));

  // R4
  strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(en) && ctl) |-> (len_cnt == 8'(CFG_W)));

  // R4
  idle_bit_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> !sbit);

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vld |=> !vld);

  // R6
  valid_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    vld |-> ($past(!eoc) && $past(eoc, 2)));

  // R9
  reconfig_locked_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(en) && $past(run)) |-> ($past(fall) && $past(last)));
endmodule

bind sensor_seq ss_chk #(.GAP(GAP), .CFG_W(CFG_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .ctl  (sens_ctl_o),
  .srst (sens_rst_o),
  .en   (sens_cfg_en_o),
  .sbit (sens_cfg_bit_o),
  .eoc  (sens_eoc_i),
  .vld  (smp_valid_o),
  .run  (run_w),
  .fall (eoc_fall),
  .last (eos_last)
);

// File: tb/tb_sensor_seq.sv
`timescale 1ns/1ps
module tb_sensor_seq;
  localparam int GAP = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0, stop_i = 1'b0;
  logic [7:0] cfg_i = '0;
  logic       sens_eoc_i = 1'b0, sens_eos_i = 1'b0;
  logic [5:0] sens_data_i = '0;
  logic       sens_ctl_o, sens_rst_o, sens_cfg_en_o, sens_cfg_bit_o;
  logic       smp_valid_o;
  logic [5:0] smp_data_o;
  logic [2:0] smp_chan_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sensor_seq #(.GAP(GAP)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .cfg_i(cfg_i),
    .sens_ctl_o(sens_ctl_o), .sens_rst_o(sens_rst_o),
    .sens_cfg_en_o(sens_cfg_en_o), .sens_cfg_bit_o(sens_cfg_bit_o),
    .sens_eoc_i(sens_eoc_i), .sens_eos_i(sens_eos_i), .sens_data_i(sens_data_i),
    .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o), .smp_chan_o(smp_chan_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // control outputs packed as {ctl, rst, en}
  function automatic int ctlv();
    return {29'd0, sens_ctl_o, sens_rst_o, sens_cfg_en_o};
  endfunction

  task automatic chk_parked(input string req);
    chk(ctlv() == 3'b010 && !sens_cfg_bit_o && !smp_valid_o, req, ctlv(), 3'b010);
  endtask

  // strobe window: CFG_W cycles, MSB first, then strobe low
  task automatic chk_shift(input logic [7:0] c);
    for (int i = 0; i < 8; i++) begin
      chk(sens_cfg_en_o == 1'b1, "R4 strobe", sens_cfg_en_o, 1);
      chk(sens_cfg_bit_o == c[7-i], "R4 bit", sens_cfg_bit_o, c[7-i]);
      step();
    end
    chk(ctlv() == 3'b100 && !sens_cfg_bit_o, "R4 strobe end", ctlv(), 3'b100);
  endtask

  task automatic bringup(input logic [7:0] c);
    start_i = 1'b1; cfg_i = c;
    step();
    start_i = 1'b0;
    for (int i = 0; i < GAP; i++) begin
      chk(ctlv() == 3'b110, "R2 enable phase", ctlv(), 3'b110);
      step();
    end
    for (int i = 0; i < GAP; i++) begin
      chk(ctlv() == 3'b100, "R3 release phase", ctlv(), 3'b100);
      step();
    end
    chk_shift(c);
  endtask

  // one conversion; when nxt_cfg is given (reconf), the strobe must open with it
  task automatic conv(input logic [5:0] d, input bit eos, input int ch,
                      input bit reconf, input logic [7:0] nxt_cfg);
    sens_eoc_i = 1'b1; sens_eos_i = eos; sens_data_i = d;
    step();
    chk(!smp_valid_o && !sens_cfg_en_o, "R6 no early valid", smp_valid_o, 0);
    sens_eoc_i = 1'b0; sens_eos_i = 1'b0;
    step();
    chk(smp_valid_o == 1'b1, "R6 valid", smp_valid_o, 1);
    chk(smp_data_o == d, "R6 data", smp_data_o, d);
    chk(smp_chan_o == ch[2:0], "R7 chan", smp_chan_o, ch);
    if (reconf) begin
      chk_shift(nxt_cfg);
    end else begin
      chk(!sens_cfg_en_o, "R9 held", sens_cfg_en_o, 0);
      step();
      chk(!smp_valid_o, "R6 pulse", smp_valid_o, 0);
      chk(ctlv() == 3'b100, "R8 controls steady", ctlv(), 3'b100);
    end
  endtask

  task automatic run_seq(input int n, input int base);
    for (int j = 0; j < n; j++)
      conv(6'(base + 7 * j), j == n - 1, j, 1'b0, 8'h00);
  endtask

  task automatic do_stop();
    stop_i = 1'b1;
    step();
    stop_i = 1'b0;
    chk_parked("R10 stop");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] pats [4] = '{6'h00, 6'h3F, 6'h15, 6'h2A};
    step(); step();
    chk_parked("R1 in reset");
    rst = 1'b0;
    step();
    chk_parked("R1 after reset");

    // R5: all-ones mode ignored from idle
    start_i = 1'b1; cfg_i = 8'hC5;
    step();
    start_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      chk_parked("R5 mode 11 ignored");
      step();
    end

    // sweep modes and patterns; R8 two sequences each
    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] c;
        c = {2'(m), pats[p]};
        bringup(c);
        run_seq(m + 1, p * 5 + m);
        run_seq(m + 1, p * 3 + 11);
        do_stop();
      end
    end

    // R9: reconfiguration held until the sequence closes
    bringup(8'h4B);
    conv(6'd9, 1'b0, 0, 1'b0, 8'h00);
    start_i = 1'b1; cfg_i = 8'h96;
    step();
    start_i = 1'b0;
    conv(6'd10, 1'b0, 1, 1'b0, 8'h00);
    conv(6'd11, 1'b0, 2, 1'b0, 8'h00);
    conv(6'd12, 1'b1, 3, 1'b1, 8'h96);
    run_seq(3, 20);

    // R5: all-ones mode ignored while converting
    start_i = 1'b1; cfg_i = 8'hFF;
    step();
    start_i = 1'b0;
    run_seq(2, 40);
    run_seq(2, 50);

    // R11: reset during conversion
    sens_eoc_i = 1'b1; sens_data_i = 6'd33;
    step();
    rst = 1'b1;
    sens_eoc_i = 1'b0;
    step();
    chk_parked("R11 reset mid-run");
    rst = 1'b0;
    step();
    chk_parked("R11 after reset");

    // R10: restart after stop
    bringup(8'h27);
    run_seq(1, 5);
    do_stop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule